// File: doc/BRIEF.md
# Prefix-Tree Magnitude Comparator

This block compares two unsigned W-bit operands, `a` and `b`, without forming a difference. Every bit position first yields a local verdict: does `b` win at this bit, or does `a` win? A parallel reduction tree then merges these verdicts. At each merge, the more significant group wins whenever it has already decided. The less significant group counts only when the more significant group is tied.

The tree walks from the most significant bit toward the least significant. It carries just two flags per group. Equality is never computed inside the tree. It is read off at the root as "neither flag set".

The parameter `BALANCED` selects the tree shape:

- **1:** a balanced tree of ceil(log2 W) merge levels.
- **0:** a linear chain from the top bit down.

Both shapes produce the same outputs, because the merge is associative. The block is purely combinational and is meant to sit in a datapath wherever an ordering decision is needed.

Top module: `magcmp_tree`

## Requirements
- R1: `gt` is 1 exactly when `b` is greater than `a`, treating both as unsigned binary numbers.
- R2: `lt` is 1 exactly when `b` is less than `a`, treating both as unsigned.
- R3: `eq` is 1 exactly when `a` and `b` are bit-for-bit identical.
- R4: For any input pair, exactly one of `gt`, `lt` and `eq` is 1.
- R5: The highest bit position where `a` and `b` differ alone decides the result. Inverting only bit W-1 of one operand gives `gt` = `b[W-1]` whatever the lower bits hold. Inverting only bit 0 gives `gt` = `b[0]`.
- R6: With W = 1 the outputs come from the single bit-0 verdict, with no merge stage: (a,b) = (0,1) gives `gt`, (1,0) gives `lt`, and equal bits give `eq`.
- R7: The balanced tree (BALANCED = 1) and the linear chain (BALANCED = 0) give identical outputs for every input pair. Both also match a bit-serial reference that scans from the top bit down to the first differing bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First unsigned operand |
| b | input | W | Second unsigned operand |
| gt | output | 1 | High when b > a |
| lt | output | 1 | High when b < a |
| eq | output | 1 | High when a == b |

## Verification
The two flags `gt` and `lt` come from the same tree. So a single input pair can assert both local verdicts at once: an upper bit favours one operand while lower bits favour the other. The bench provokes this conflict on purpose. It sets the most significant difference against an all-opposing lower field (for example 0x7FF..F versus 0x800..0), and it also runs every 8-bit pair exhaustively. Each case is judged by requiring that only the flag belonging to the highest differing bit survives, that `eq` stays low, and that the balanced tree and the chain agree with the bit-serial reference.

// File: rtl/magcmp_tree.sv
module magcmp_tree #(
  parameter int W        = 32,
  parameter bit BALANCED = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         gt,
  output logic         lt,
  output logic         eq
);
  localparam int LV = (W > 1) ? $clog2(W) : 0;
  localparam int P  = 1 << LV;

  // pair packing: [1] = b wins, [0] = a wins
  function automatic logic [1:0] merge(input logic [1:0] hi, input logic [1:0] lo);
    return {hi[1] | (~hi[0] & lo[1]), hi[0] | (~hi[1] & lo[0])};
  endfunction

  logic [1:0] leaf [W];
  logic [1:0] root;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_leaf
      assign leaf[i] = {~a[W-1-i] & b[W-1-i], a[W-1-i] & ~b[W-1-i]};
    end

    if (BALANCED) begin : g_tree
      logic [1:0] node [1:2*P-1];
      for (i = 0; i < P; i++) begin : g_pad
        if (i < W) begin : g_use
          assign node[P+i] = leaf[i];
        end else begin : g_zero
          assign node[P+i] = 2'b00;
        end
      end
      for (i = 1; i < P; i++) begin : g_node
        assign node[i] = merge(node[2*i], node[2*i+1]);
      end
      assign root = node[1];
    end else begin : g_chain
      logic [1:0] acc [W];
      assign acc[0] = leaf[0];
      for (i = 1; i < W; i++) begin : g_step
        assign acc[i] = merge(acc[i-1], leaf[i]);
      end
      assign root = acc[W-1];
    end
  endgenerate

  assign gt = root[1];
  assign lt = root[0];
  assign eq = ~root[1] & ~root[0];
endmodule

// File: rtl/magcmp_tree_chk.sv
module magcmp_tree_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         gt,
  input logic         lt,
  input logic         eq
);
  always_comb begin
    a_r1_gt_order: assert (gt == (b > a));
    a_r2_lt_order: assert (lt == (b < a));
    a_r3_eq_match: assert (eq == (a == b));
    a_r4_one_hot:  assert ($onehot({gt, lt, eq}));
  end
endmodule

bind magcmp_tree magcmp_tree_chk #(.W(W)) u_chk (
  .a(a), .b(b), .gt(gt), .lt(lt), .eq(eq)
);

// File: tb/sim_magcmp_tree.sv
`timescale 1ns/1ps
module sim_magcmp_tree;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  logic [63:0] a64, b64;
  logic [7:0]  a8, b8;
  logic [3:0]  a4, b4;
  logic        a1, b1;
  logic gt0, lt0, eq0, gt1, lt1, eq1;
  logic gt2, lt2, eq2, gt3, lt3, eq3;
  logic gt4, lt4, eq4, gt5, lt5, eq5;

  magcmp_tree #(.W(64), .BALANCED(1'b1)) u0 (.a(a64), .b(b64), .gt(gt0), .lt(lt0), .eq(eq0));
  magcmp_tree #(.W(64), .BALANCED(1'b0)) u1 (.a(a64), .b(b64), .gt(gt1), .lt(lt1), .eq(eq1));
  magcmp_tree #(.W(8),  .BALANCED(1'b1)) u2 (.a(a8),  .b(b8),  .gt(gt2), .lt(lt2), .eq(eq2));
  magcmp_tree #(.W(8),  .BALANCED(1'b0)) u3 (.a(a8),  .b(b8),  .gt(gt3), .lt(lt3), .eq(eq3));
  magcmp_tree #(.W(4),  .BALANCED(1'b1)) u4 (.a(a4),  .b(b4),  .gt(gt4), .lt(lt4), .eq(eq4));
  magcmp_tree #(.W(1),  .BALANCED(1'b1)) u5 (.a(a1),  .b(b1),  .gt(gt5), .lt(lt5), .eq(eq5));

  function automatic logic [2:0] rel(input logic [63:0] x, input logic [63:0] y);
    return {y > x, y < x, y == x};
  endfunction

  function automatic logic [2:0] ripple(input logic [63:0] x, input logic [63:0] y, input int w);
    for (int k = w - 1; k >= 0; k--)
      if (x[k] != y[k]) return y[k] ? 3'b100 : 3'b010;
    return 3'b001;
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual={gt,lt,eq}=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset_state;
    a64 = '0; b64 = '0; a8 = '0; b8 = '0; a4 = '0; b4 = '0; a1 = 1'b0; b1 = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R3 zero operands w64", {gt0, lt0, eq0}, 3'b001);
    chk("R3 zero operands w8",  {gt2, lt2, eq2}, 3'b001);
  endtask

  task automatic t_width1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); a1 = k[0]; b1 = k[1];
      @(negedge clk);
      chk("R6 single bit", {gt5, lt5, eq5}, ripple({63'b0, a1}, {63'b0, b1}, 1));
    end
  endtask

  task automatic t_exhaustive8;
    for (int k = 0; k < 65536; k++) begin
      @(posedge clk);
      a8 = k[7:0]; b8 = k[15:8]; a4 = k[3:0]; b4 = k[11:8];
      @(negedge clk);
      chk("R1 R2 R3 R4 balanced w8", {gt2, lt2, eq2}, rel({56'b0, a8}, {56'b0, b8}));
      chk("R7 chain w8 vs ripple", {gt3, lt3, eq3}, ripple({56'b0, a8}, {56'b0, b8}, 8));
      if (k[7:4] == 4'd0 && k[15:12] == 4'd0)
        chk("R1 R2 R3 padded w4", {gt4, lt4, eq4}, rel({60'b0, a4}, {60'b0, b4}));
    end
  endtask

  task automatic t_msb_conflict;
    @(posedge clk); a64 = 64'h7FFF_FFFF_FFFF_FFFF; b64 = 64'h8000_0000_0000_0000;
    @(negedge clk);
    chk("R5 msb beats lower field", {gt0, lt0, eq0}, 3'b100);
    chk("R5 msb beats lower field chain", {gt1, lt1, eq1}, 3'b100);
    @(posedge clk); a64 = 64'h8000_0000_0000_0000; b64 = 64'h7FFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    chk("R5 msb beats lower field rev", {gt0, lt0, eq0}, 3'b010);
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); a64 = {$urandom, $urandom}; b64 = a64 ^ 64'h8000_0000_0000_0000;
      @(negedge clk);
      chk("R5 msb only", {gt0, lt0, eq0}, {b64[63], ~b64[63], 1'b0});
      @(posedge clk); b64 = a64 ^ 64'h1;
      @(negedge clk);
      chk("R5 lsb only", {gt0, lt0, eq0}, {b64[0], ~b64[0], 1'b0});
      chk("R5 lsb only chain", {gt1, lt1, eq1}, {b64[0], ~b64[0], 1'b0});
    end
  endtask

  task automatic t_random64;
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk);
      a64 = {$urandom, $urandom};
      b64 = (k % 5 == 0) ? a64 : {$urandom, $urandom};
      if (k % 7 == 0) b64[63:32] = a64[63:32];
      @(negedge clk);
      chk("R1 R2 R3 R4 balanced w64", {gt0, lt0, eq0}, rel(a64, b64));
      chk("R7 chain w64 vs ripple", {gt1, lt1, eq1}, ripple(a64, b64, 64));
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_width1();
    t_exhaustive8();
    t_msb_conflict();
    t_random64();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule